// File: doc/BRIEF.md
# Grouped GPIO Interrupt Controller

This block turns a set of already-synchronised GPIO lines into interrupt requests. The lines are split into groups of eight. Every line has three things of its own: a 3-bit trigger selector, a mask bit and a sticky pending flag. A single combined request line covers every group. It is high while any line anywhere is both pending and unmasked.

Software reaches the block through a single-cycle register port. A write is committed on the clock edge where the write enable is high. A read returns data combinationally from the address. There are three register banks, holding trigger selection, masking and pending state. Each bank gives one 32-bit word per group, and the words sit four bytes apart. A typical handler finds the set pending bits, services those lines, and then acknowledges them by writing ones back to the pending word.

Top module: `gpint_ctrl`

## Requirements
- R1: Group g's trigger word is at 0x700+4g, its mask word at 0x900+4g and its pending word at 0xA00+4g. Any other address reads 0, and a write to it changes no state.
- R2: In the trigger word, line n uses bits [4n+2:4n]. Bit 4n+3 always reads 0, whatever was written to it.
- R3: Trigger codes work as follows: 0 is level low, 1 is level high, 2 is a falling edge, 3 is a rising edge and 4 is either edge. The edge codes compare the input with its value one clock earlier. The pending bit shows the event on the clock edge that samples it.
- R4: Trigger codes 5, 6 and 7 never set a pending bit.
- R5: Writing 1 to a pending bit clears it. Writing 0 leaves it unchanged. Only a write with a 1 in that bit position clears a pending bit.
- R6: If a line's trigger condition is met on the same edge as a clear of its pending bit, the bit stays set.
- R7: In the level modes the pending bit is set again on every edge where the level is still active. A clear therefore has no effect until the level goes away.
- R8: A pending bit is set whatever the state of its mask bit.
- R9: `irq_out` is high exactly when at least one line in any group is pending and has mask bit 0. Mask bit 1 blocks the line.
- R10: After reset, every trigger word is 0, every mask word reads 0xFF and every pending word is 0. Bits 8 to 31 of the mask and pending words always read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | 12 | Register byte address |
| reg_wdata | input | 32 | Write data |
| reg_we | input | 1 | Write enable; the write is committed on the rising edge |
| reg_rdata | output | 32 | Combinational read data for `reg_addr` |
| gpio_in | input | 32 | Synchronised GPIO lines; group g uses bits [8g+7:8g] |
| irq_out | output | 1 | Combined interrupt request |

## Verification
Some properties are checked by assertions on every cycle for every line. A detected trigger always leaves the pending bit set on the next edge. A pending bit falls only when a clear write carries a 1 in its position. A line with an unused code never becomes pending. A rising-edge line with no rising transition stays clear. Other behaviour only the bench's scenarios can show. These are the value of each trigger code, the address decode and reserved-bit read-back, the reset values, a level line re-arming after a clear, and masking gating `irq_out` across groups. The bench drives a table of input transitions per trigger code and pairs each one with a clear on the same edge. This exposes both the detection itself and the rule that a trigger beats a clear.

// File: rtl/gpint_pkg.sv
package gpint_pkg;

    localparam int LINES_PER_GRP = 8;
    localparam int FIELD_W       = 4;
    localparam int CODE_W        = 3;
    localparam int REG_W         = 32;

    localparam logic [11:0] TRIG_BANK = 12'h700;
    localparam logic [11:0] MASK_BANK = 12'h900;
    localparam logic [11:0] PEND_BANK = 12'hA00;
    localparam int          GRP_STRIDE = 4;

    typedef enum logic [CODE_W-1:0] {
        TRIG_LOW  = 3'd0,
        TRIG_HIGH = 3'd1,
        TRIG_FALL = 3'd2,
        TRIG_RISE = 3'd3,
        TRIG_BOTH = 3'd4
    } trig_e;

    // Bits of a trigger word that hold a code; the spare top bit of each field stays 0.
    function automatic logic [REG_W-1:0] code_keep_mask(input int lines);
        logic [REG_W-1:0] m;
        m = '0;
        for (int n = 0; n < lines; n++) begin
            m[n*FIELD_W +: CODE_W] = '1;
        end
        return m;
    endfunction

endpackage

// File: rtl/gpint_detect.sv
module gpint_detect
    import gpint_pkg::*;
(
    input  logic [CODE_W-1:0] code,
    input  logic              cur,
    input  logic              prev,
    output logic              hit
);

    always_comb begin
        case (code)
            TRIG_LOW:  hit = ~cur;
            TRIG_HIGH: hit = cur;
            TRIG_FALL: hit = prev & ~cur;
            TRIG_RISE: hit = ~prev & cur;
            TRIG_BOTH: hit = prev ^ cur;
            default:   hit = 1'b0;
        endcase
    end

endmodule

// File: rtl/gpint_group.sv
module gpint_group
    import gpint_pkg::*;
#(
    parameter int LINES = LINES_PER_GRP
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 trig_we,
    input  logic                 mask_we,
    input  logic                 pend_we,
    input  logic [REG_W-1:0]     wdata,
    input  logic [LINES-1:0]     cur,
    input  logic [LINES-1:0]     prev,
    output logic [REG_W-1:0]     trig_q_o,
    output logic [LINES-1:0]     mask_q_o,
    output logic [LINES-1:0]     pend_q_o,
    output logic                 req
);

    localparam int TRIG_W = LINES * FIELD_W;
    localparam logic [REG_W-1:0] KEEP = code_keep_mask(LINES);

    typedef struct packed {
        logic [REG_W-1:0] trig;
        logic [LINES-1:0] mask;
        logic [LINES-1:0] pend;
    } grp_state_t;

    grp_state_t st_d, st_q;
    logic [LINES-1:0] hit;
    logic [LINES-1:0] clr;

    generate
        for (genvar i = 0; i < LINES; i++) begin : g_line
            gpint_detect u_det (
                .code (st_q.trig[i*FIELD_W +: CODE_W]),
                .cur  (cur[i]),
                .prev (prev[i]),
                .hit  (hit[i])
            );
        end
    endgenerate

    always_comb begin
        st_d = st_q;
        clr  = pend_we ? wdata[LINES-1:0] : '0;
        if (trig_we) st_d.trig = wdata & KEEP;
        if (mask_we) st_d.mask = wdata[LINES-1:0];
        st_d.pend = (st_q.pend & ~clr) | hit;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.trig <= '0;
            st_q.mask <= '1;
            st_q.pend <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign trig_q_o = st_q.trig;
    assign mask_q_o = st_q.mask;
    assign pend_q_o = st_q.pend;
    assign req      = |(st_q.pend & ~st_q.mask);

    generate
        for (genvar i = 0; i < LINES; i++) begin : g_chk
            // R6
            trig_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
                hit[i] |=> st_q.pend[i]);
            // R5
            pend_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (st_q.pend[i] && !(pend_we && wdata[i])) |=> st_q.pend[i]);
            // R4
            spare_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (st_q.trig[i*FIELD_W +: CODE_W] >= 3'd5 && !st_q.pend[i]) |=> !st_q.pend[i]);
            // R3
            rise_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (st_q.trig[i*FIELD_W +: CODE_W] == TRIG_RISE && !(cur[i] && !prev[i])
                 && !st_q.pend[i]) |=> !st_q.pend[i]);
        end
    endgenerate

    if (TRIG_W > REG_W) begin : g_bad_width
        initial $error("trigger word wider than register");
    end

endmodule

// File: rtl/gpint_ctrl.sv
module gpint_ctrl
    import gpint_pkg::*;
#(
    parameter int NUM_GROUPS = 4,
    parameter int ADDR_W     = 12
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic [ADDR_W-1:0]                 reg_addr,
    input  logic [REG_W-1:0]                  reg_wdata,
    input  logic                              reg_we,
    output logic [REG_W-1:0]                  reg_rdata,
    input  logic [NUM_GROUPS*LINES_PER_GRP-1:0] gpio_in,
    output logic                              irq_out
);

    localparam int NLINES = NUM_GROUPS * LINES_PER_GRP;

    typedef struct packed {
        logic [NLINES-1:0] prev;
    } top_state_t;

    top_state_t st_d, st_q;

    logic [REG_W-1:0]         grp_trig [NUM_GROUPS];
    logic [LINES_PER_GRP-1:0] grp_mask [NUM_GROUPS];
    logic [LINES_PER_GRP-1:0] grp_pend [NUM_GROUPS];
    logic [NUM_GROUPS-1:0]    sel_trig, sel_mask, sel_pend, grp_req;

    generate
        for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
            localparam logic [ADDR_W-1:0] A_TRIG = ADDR_W'(TRIG_BANK + g*GRP_STRIDE);
            localparam logic [ADDR_W-1:0] A_MASK = ADDR_W'(MASK_BANK + g*GRP_STRIDE);
            localparam logic [ADDR_W-1:0] A_PEND = ADDR_W'(PEND_BANK + g*GRP_STRIDE);

            assign sel_trig[g] = (reg_addr == A_TRIG);
            assign sel_mask[g] = (reg_addr == A_MASK);
            assign sel_pend[g] = (reg_addr == A_PEND);

            gpint_group #(.LINES(LINES_PER_GRP)) u_grp (
                .clk      (clk),
                .rst_n    (rst_n),
                .trig_we  (reg_we & sel_trig[g]),
                .mask_we  (reg_we & sel_mask[g]),
                .pend_we  (reg_we & sel_pend[g]),
                .wdata    (reg_wdata),
                .cur      (gpio_in[g*LINES_PER_GRP +: LINES_PER_GRP]),
                .prev     (st_q.prev[g*LINES_PER_GRP +: LINES_PER_GRP]),
                .trig_q_o (grp_trig[g]),
                .mask_q_o (grp_mask[g]),
                .pend_q_o (grp_pend[g]),
                .req      (grp_req[g])
            );
        end
    endgenerate

    always_comb begin
        st_d.prev = gpio_in;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        reg_rdata = '0;
        for (int g = 0; g < NUM_GROUPS; g++) begin
            if (sel_trig[g]) reg_rdata = grp_trig[g];
            if (sel_mask[g]) reg_rdata = REG_W'(grp_mask[g]);
            if (sel_pend[g]) reg_rdata = REG_W'(grp_pend[g]);
        end
    end

    assign irq_out = |grp_req;

endmodule

// File: tb/gpint_ctrl_tb.sv
module gpint_ctrl_tb_top;

    localparam int NG = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic        reg_we = 1'b0;
    logic [31:0] reg_rdata;
    logic [31:0] gpio = 32'hFFFF_FFFF;
    logic        irq_out;

    int total = 0;
    int bad = 0;
    bit done = 0;

    gpint_ctrl #(.NUM_GROUPS(NG), .ADDR_W(12)) dut_i (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_we(reg_we), .reg_rdata(reg_rdata), .gpio_in(gpio), .irq_out(irq_out)
    );

    always #10 clk = ~clk;

    function automatic logic [11:0] a_trig(int g); return 12'h700 + 12'(g*4); endfunction
    function automatic logic [11:0] a_mask(int g); return 12'h900 + 12'(g*4); endfunction
    function automatic logic [11:0] a_pend(int g); return 12'hA00 + 12'(g*4); endfunction

    // {code[2:0], level_before, level_after, expected_pending}
    localparam logic [5:0] VEC [15] = '{
        6'b000101, 6'b000110, 6'b001011, 6'b001000, 6'b001111,
        6'b010101, 6'b010010, 6'b011011, 6'b011100, 6'b100011,
        6'b100101, 6'b100110, 6'b101010, 6'b110100, 6'b111010
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_we = 1'b1;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    initial begin
        #(20 * 100000);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R10 reset values
        rd(a_trig(0), v); chk("R10 trig0 reset", v, 32'h0);
        rd(a_mask(0), v); chk("R10 mask0 reset", v, 32'hFF);
        rd(a_mask(3), v); chk("R10 mask3 reset", v, 32'hFF);
        rd(a_pend(2), v); chk("R10 pend2 reset", v, 32'h0);
        chk("R10 irq reset", {31'b0, irq_out}, 32'h0);

        // R1 unmapped address
        wr(12'h710, 32'hFFFF_FFFF);
        rd(12'h710, v); chk("R1 unmapped read", v, 32'h0);
        rd(12'h800, v); chk("R1 gap read", v, 32'h0);
        rd(a_trig(0), v); chk("R1 no side effect", v, 32'h0);

        // R10 upper bits of mask
        wr(a_mask(0), 32'h1234_56A5);
        rd(a_mask(0), v); chk("R10 mask upper zero", v, 32'hA5);
        wr(a_mask(0), 32'hFF);

        // R2 spare field bits
        wr(a_trig(2), 32'hFFFF_FFFF);
        rd(a_trig(2), v); chk("R2 spare bits", v, 32'h7777_7777);

        // R8 pending while masked, R9 gating
        wr(a_trig(0), 32'h3);
        gpio[0] = 1'b0;
        repeat (2) @(negedge clk);
        gpio[0] = 1'b1;
        @(negedge clk);
        rd(a_pend(0), v); chk("R8 pend set while masked", v, 32'h1);
        chk("R9 masked no irq", {31'b0, irq_out}, 32'h0);
        wr(a_mask(0), 32'hFE);
        chk("R9 unmasked irq", {31'b0, irq_out}, 32'h1);
        wr(a_pend(0), 32'h0);
        rd(a_pend(0), v); chk("R5 zero write keeps", v, 32'h1);
        wr(a_pend(0), 32'h2);
        rd(a_pend(0), v); chk("R5 other bit keeps", v, 32'h1);
        wr(a_pend(0), 32'h1);
        rd(a_pend(0), v); chk("R5 one clears", v, 32'h0);
        chk("R9 irq drops", {31'b0, irq_out}, 32'h0);
        wr(a_mask(0), 32'hFF);

        // R7 level re-arm, R9 across groups
        wr(a_trig(3), 32'h1 << 20);
        @(negedge clk);
        rd(a_pend(3), v); chk("R7 level high sets", v, 32'h20);
        wr(a_pend(3), 32'h20);
        rd(a_pend(3), v); chk("R7 clear ignored while active", v, 32'h20);
        wr(a_mask(3), 32'hDF);
        chk("R9 group3 irq", {31'b0, irq_out}, 32'h1);
        gpio[29] = 1'b0;
        wr(a_pend(3), 32'h20);
        rd(a_pend(3), v); chk("R7 clear after level gone", v, 32'h0);
        chk("R9 group3 irq drops", {31'b0, irq_out}, 32'h0);
        wr(a_mask(3), 32'hFF);

        // R3 R4 R6 trigger table on group 1 line 3; clear lands on the sampling edge
        for (int e = 0; e < 15; e++) begin
            logic [2:0] code;
            code = VEC[e][5:3];
            wr(a_trig(1), 32'(code) << 12);
            gpio[11] = VEC[e][2];
            repeat (2) @(negedge clk);
            gpio[11] = VEC[e][1];
            reg_addr = a_pend(1); reg_wdata = 32'h8; reg_we = 1'b1;
            @(negedge clk);
            reg_we = 1'b0;
            rd(a_pend(1), v);
            if (code >= 3'd5)
                chk($sformatf("R4 code %0d", code), {31'b0, v[3]}, {31'b0, VEC[e][0]});
            else
                chk($sformatf("R3/R6 code %0d vec %0d", code, e), {31'b0, v[3]}, {31'b0, VEC[e][0]});
        end

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule